// File: doc/BRIEF.md
# Idle-Stalling Processor Clock Generator

This block produces the local clock of a small streaming processor. It takes a fast source clock, divides it by a programmable integer ratio and gates the result off when the processor has had nothing to do for a while. Two source clocks of different rates are offered. A one-bit select picks between them, standing in for a short or long ring oscillator. A divide field then sets the ratio anywhere from 1 to 128.

A "work available" input summarises whether the input queues hold data and the output port can accept it. Processor cycles in which this input is low are counted. After nine of them in a row, the next processor clock pulse is withheld and the clock stays stopped. A stalled flag reports this state. As soon as work returns, the next processor-cycle boundary of the still-running divider delivers a pulse, so the clock comes back within one processor period. A test bit turns stalling off entirely. The enable that gates the clock is held in a latch that is open only while the source is low, at a processor-cycle boundary, so pulses are never shortened.

Top module: `idle_stall_clkgen`

## Requirements
- R1: While rst_n is low, pclk and stalled are both low. After release, with work available, pclk toggles from the first source edge on.
- R2: With divide field value k (a 7-bit unsigned field), pclk has one rising edge every k+1 source cycles.
- R3: Field value 0 (ratio 1) passes the selected source through unchanged: pclk is high while the source is high and low while it is low.
- R4: For a ratio N of 2 or more, each pclk pulse is high for exactly floor(N/2) source cycles. No pulse is ever cut short.
- R5: A processor cycle is idle when work_avail is low at the source edge that closes it. The idle count saturates at nine. Once nine consecutive cycles are idle, no further pulse is issued, so exactly 8 rising edges follow a drop of work_avail made just after a rising edge.
- R6: Any source edge that samples work_avail high clears the idle count. Idle spells shorter than nine cycles therefore never stop the clock, however many of them occur.
- R7: While stopped, a rise of work_avail produces a pclk rising edge within N source cycles, and stalled is low from that edge on.
- R8: stalled rises at the source edge where a due pulse is first withheld, with the idle count at nine, and stays high with pclk low while the clock is stopped.
- R9: While stall_dis is high, pclk never stops and stalled is low. Clearing stall_dis with the idle count saturated stops the clock at the next cycle boundary.
- R10: ring_sel low selects clk_ring5 and high selects clk_ring9 as the source. ring_sel and div_cfg are changed only while rst_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ring5 | input | 1 | Faster source clock (short ring) |
| clk_ring9 | input | 1 | Slower source clock (long ring) |
| ring_sel | input | 1 | Source select, 1 = clk_ring9 |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_cfg | input | DIV_W | Divide ratio minus one |
| stall_dis | input | 1 | Test bit, 1 = never stall |
| work_avail | input | 1 | Processor has work pending |
| pclk | output | 1 | Gated, divided processor clock |
| stalled | output | 1 | Clock is currently stopped |

## Verification
The assertions watch, on every source edge, the following properties: the idle count stays at or below its cap, work clears it, stalled only rises with the count saturated, and any boundary seen with work or with the test bit set leaves the clock running. They also measure every divided pulse against floor(N/2). Only the bench scenarios show the behaviours that span many cycles. These are the exact number of pulses after work drops, the wake latency in source cycles, the period and pass-through shape at each ratio, and the effect of the source select on real-time period.

// File: rtl/idle_stall_clkgen.sv
module idle_stall_clkgen #(
  parameter int DIV_W      = 7,
  parameter int IDLE_LIMIT = 9
) (
  input  logic             clk_ring5,
  input  logic             clk_ring9,
  input  logic             ring_sel,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_cfg,
  input  logic             stall_dis,
  input  logic             work_avail,
  output logic             pclk,
  output logic             stalled
);
  localparam int IW = $clog2(IDLE_LIMIT + 1);
  localparam logic [IW-1:0] CAP = IW'(IDLE_LIMIT);

  logic             clk_src;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] cnt_nxt;
  logic [DIV_W:0]   ratio;
  logic [DIV_W:0]   half;
  logic             at_tick;
  logic             bypass;
  logic             div_q;
  logic [IW-1:0]    idle_cnt;
  logic [IW-1:0]    idle_step;
  logic             want;
  logic             gate_en;

  // R10: source choice, static outside reset
  assign clk_src = ring_sel ? clk_ring9 : clk_ring5;

  assign ratio   = {1'b0, div_cfg} + 1'b1;
  assign half    = ratio >> 1;
  assign bypass  = (div_cfg == '0);
  assign at_tick = (cnt >= div_cfg);
  assign cnt_nxt = at_tick ? '0 : cnt + 1'b1;

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '1;
      div_q <= 1'b0;
    end else begin
      cnt   <= cnt_nxt;
      div_q <= ({1'b0, cnt_nxt} < half);
    end
  end

  assign idle_step = (idle_cnt == CAP) ? idle_cnt : idle_cnt + 1'b1;

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n)          idle_cnt <= '0;
    else if (work_avail) idle_cnt <= '0;
    else if (at_tick)    idle_cnt <= idle_step;
  end

  assign want = stall_dis | work_avail | (idle_step < CAP);

  // enable may only move while the source is low at a cycle boundary
  always_latch begin
    if (!rst_n)                  gate_en = 1'b0;
    else if (!clk_src && at_tick) gate_en = want;
  end

  assign pclk = (bypass ? clk_src : div_q) & gate_en;

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n)       stalled <= 1'b0;
    else if (at_tick) stalled <= ~gate_en;
  end
endmodule

// File: rtl/idle_stall_clkgen_chk.sv
module idle_stall_clkgen_chk #(
  parameter int DIV_W      = 7,
  parameter int IDLE_LIMIT = 9
) (
  input logic                                  clk_src,
  input logic                                  rst_n,
  input logic                                  pclk,
  input logic                                  stalled,
  input logic                                  work_avail,
  input logic                                  stall_dis,
  input logic [DIV_W-1:0]                      div_cfg,
  input logic [$clog2(IDLE_LIMIT+1)-1:0]       idle_cnt,
  input logic                                  at_tick
);
  localparam int IW = $clog2(IDLE_LIMIT + 1);

  logic [DIV_W:0] hi_run;
  logic [DIV_W:0] exp_half;
  assign exp_half = ({1'b0, div_cfg} + 1'b1) >> 1;

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) hi_run <= '0;
    else begin
      hi_run <= pclk ? hi_run + 1'b1 : '0;
      if (!pclk && hi_run != '0 && div_cfg != '0)
        p_width_r4: assert (hi_run == exp_half);
    end
  end

  p_idle_cap_r5: assert property (@(posedge clk_src) disable iff (!rst_n)
    idle_cnt <= IW'(IDLE_LIMIT));

  p_work_clears_r6: assert property (@(posedge clk_src) disable iff (!rst_n)
    work_avail |=> idle_cnt == '0);

  p_wake_r7: assert property (@(posedge clk_src) disable iff (!rst_n)
    (work_avail && at_tick) |=> !stalled);

  p_stall_entry_r8: assert property (@(posedge clk_src) disable iff (!rst_n)
    $rose(stalled) |-> idle_cnt == IW'(IDLE_LIMIT));

  p_no_stall_r9: assert property (@(posedge clk_src) disable iff (!rst_n)
    (stall_dis && at_tick) |=> !stalled);
endmodule

bind idle_stall_clkgen idle_stall_clkgen_chk #(.DIV_W(DIV_W), .IDLE_LIMIT(IDLE_LIMIT)) u_chk (
  .clk_src(clk_src), .rst_n(rst_n), .pclk(pclk), .stalled(stalled),
  .work_avail(work_avail), .stall_dis(stall_dis), .div_cfg(div_cfg),
  .idle_cnt(idle_cnt), .at_tick(at_tick)
);

// File: tb/idle_stall_clkgen_tb.sv
module idle_stall_clkgen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SLOW_PERIOD = 18;

  logic clk_a = 1'b0, clk_b = 1'b0;
  logic ring_sel = 1'b0, rst_n = 1'b0, stall_dis = 1'b0, work_avail = 1'b1;
  logic [6:0] div_cfg = '0;
  logic pclk, stalled;
  int checks = 0, fails = 0, pedges = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_a = ~clk_a;
  always #(SLOW_PERIOD/2) clk_b = ~clk_b;
  always @(posedge pclk) pedges++;

  idle_stall_clkgen u_dut (
    .clk_ring5(clk_a), .clk_ring9(clk_b), .ring_sel(ring_sel), .rst_n(rst_n),
    .div_cfg(div_cfg), .stall_dis(stall_dis), .work_avail(work_avail),
    .pclk(pclk), .stalled(stalled));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_src(input int n);
    repeat (n) begin
      if (ring_sel) @(posedge clk_b); else @(posedge clk_a);
    end
    #1;
  endtask

  task automatic measure(input int n, output int e, output int h);
    int p0 = pedges;
    h = 0;
    repeat (n) begin
      wait_src(1);
      if (pclk) h++;
    end
    e = pedges - p0;
  endtask

  task automatic do_reset(input int cfg, input bit sel, input bit sd, input bit w);
    rst_n = 1'b0; div_cfg = 7'(cfg); ring_sel = sel; stall_dis = sd; work_avail = w;
    wait_src(3);
    check(pclk == 1'b0 && stalled == 1'b0, "R1 reset outputs", {pclk, stalled}, 0);
    rst_n = 1'b1;
    wait_src(2 * (cfg + 1) + 4);
  endtask

  task automatic t_reset();
    int e, h;
    do_reset(1, 0, 0, 1);
    measure(8, e, h);
    check(e == 4, "R1 clock runs after reset", e, 4);
  endtask

  task automatic t_ratio(input int cfg);
    int n = cfg + 1, e, h;
    do_reset(cfg, 0, 0, 1);
    measure(4 * n, e, h);
    check(e == 4, "R2 edges per 4 periods", e, 4);
    if (n >= 2) check(h == 4 * (n / 2), "R4 high source cycles", h, 4 * (n / 2));
    else begin
      check(h == 4, "R3 pass-through high", h, 4);
      #(CLK_PERIOD / 2);
      check(pclk == 1'b0, "R3 pass-through low phase", pclk, 0);
    end
  endtask

  task automatic t_stall_wake();
    int e, h, k, p0;
    do_reset(2, 0, 0, 1);
    @(posedge pclk); #1;
    work_avail = 1'b0;
    measure(90, e, h);
    check(e == 8, "R5 pulses after work drops", e, 8);
    check(stalled == 1'b1, "R8 stalled while stopped", stalled, 1);
    measure(30, e, h);
    check(e == 0 && h == 0, "R8 clock stays stopped", e, 0);
    wait_src(1);
    work_avail = 1'b1;
    k = 0; p0 = pedges;
    while (pedges == p0 && k < 10) begin wait_src(1); k++; end
    check(k >= 1 && k <= 3, "R7 wake latency in source cycles", k, 3);
    check(stalled == 1'b0, "R7 stalled clears on restored edge", stalled, 0);
  endtask

  task automatic t_idle_reset();
    int p0;
    do_reset(1, 0, 0, 1);
    p0 = pedges;
    repeat (5) begin
      work_avail = 1'b0; wait_src(14);
      work_avail = 1'b1; wait_src(2);
    end
    check(pedges - p0 == 40, "R6 short idle spells never stall", pedges - p0, 40);
    check(stalled == 1'b0, "R6 stalled stays low", stalled, 0);
  endtask

  task automatic t_disable();
    int e, h;
    do_reset(1, 0, 1, 0);
    wait_src(20);
    measure(40, e, h);
    check(e == 20, "R9 clock runs with stall disabled", e, 20);
    check(stalled == 1'b0, "R9 no stall flag", stalled, 0);
    stall_dis = 1'b0;
    measure(40, e, h);
    check(e == 0, "R9 clearing test bit stops clock", e, 0);
    check(stalled == 1'b1, "R9 stalled after clearing bit", stalled, 1);
    stall_dis = 1'b1;
    measure(40, e, h);
    check(e == 20, "R9 setting test bit restarts", e, 20);
  endtask

  task automatic t_ring();
    int e, h;
    realtime t0, t1;
    do_reset(2, 1, 0, 1);
    measure(30, e, h);
    check(e == 10, "R10 edges over slow source", e, 10);
    @(posedge pclk); t0 = $realtime;
    @(posedge pclk); t1 = $realtime;
    check((t1 - t0) > 53.5 && (t1 - t0) < 54.5, "R10 period on slow source",
          int'(t1 - t0), 3 * SLOW_PERIOD);
  endtask

  initial begin
    t_reset();
    t_ratio(0);
    t_ratio(1);
    t_ratio(3);
    t_ratio(4);
    t_ratio(127);
    t_stall_wake();
    t_idle_reset();
    t_disable();
    t_ring();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule